// File: doc/BRIEF.md
# Complex LMS Weight Updater

This block adapts the control weights of a three-path analog self-interference canceller. Each path supplies a baseband in-phase/quadrature sample pair. All three paths share one residual (error) pair taken after cancellation. For every path the block forms the product of the conjugated path sample and the error. The real and imaginary parts of that product give two real gradients. Each gradient is scaled by a power-of-two step size and added into a running weight. The six weights leave the block as unsigned offset-binary codes, ready for a unipolar control-voltage converter. A zero weight therefore lands at mid-scale, which is the modulator null point.

A new sample set may arrive on every clock, qualified by `sampleEn`. The datapath has two register stages: gradient capture, then accumulation. A sample presented at clock edge n changes the weight codes after edge n+1. A one-cycle `weightValid` pulse marks each updated set of six weights. The step size is a 5-bit right-shift amount that travels with its own sample. The accumulators saturate instead of wrapping, so a weight driven hard against one rail stays there.

Top module: `lms_weight_updater`

## Requirements
- R1: While reset is asserted, and until the first sample reaches the accumulators, every weight code reads 16'h8000 and `weightValid` is 0.
- R2: For tap t, a sample with `sampleEn`=1 adds (xI*eI + xQ*eQ) >>> stepShift to the I accumulator. Here xI/xQ are `tapI`/`tapQ` bits [12t+11:12t], eI/eQ are `errI`/`errQ`, and all are signed two's complement.
- R3: The same sample adds (xI*eQ - xQ*eI) >>> stepShift to the Q accumulator of tap t. The sign follows from conjugating the tap sample.
- R4: The scaling is an arithmetic right shift that rounds toward minus infinity, so a gradient of -4096 shifted by 13 adds -1. The shift amount applied is the `stepShift` value present on that sample's own cycle, anywhere from 0 to 31.
- R5: Each accumulator keeps its value across samples. A cycle with `sampleEn`=0 changes no weight code, whatever the data inputs carry.
- R6: Each accumulator is ACC_W=28 bits signed and clamps at +2^27-1 and at -2^27 rather than wrapping.
- R7: A weight code is the top 16 bits of its accumulator with the MSB inverted (offset binary). Accumulator +4096 reads 16'h8001, -1 reads 16'h7FFF, +max reads 16'hFFFF and -max reads 16'h0000.
- R8: A sample accepted at clock edge n updates the codes after edge n+1. `weightValid` is high for exactly the cycle after edge n+1, once per accepted sample.
- R9: The three taps are independent and all use the shared error pair. Tap t's codes sit at `weightICode`/`weightQCode` bits [16t+15:16t].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleEn | input | 1 | Qualifies the sample set on this cycle |
| stepShift | input | 5 | Right-shift step size applied to this sample |
| tapI | input | 36 | In-phase samples, 12 bits per tap, tap 0 in the low bits |
| tapQ | input | 36 | Quadrature samples, 12 bits per tap |
| errI | input | 12 | Shared in-phase error sample |
| errQ | input | 12 | Shared quadrature error sample |
| weightValid | output | 1 | One-cycle pulse per updated weight set |
| weightICode | output | 48 | Offset-binary I weight codes, 16 bits per tap |
| weightQCode | output | 48 | Offset-binary Q weight codes, 16 bits per tap |

## Verification
Gradient capture for sample n+1 takes place in the same cycle as accumulation of sample n. A change of step size therefore must not reach the sample still in flight. The bench sends long back-to-back runs in which `stepShift` changes on every cycle, and mixes them with runs that have gaps. A behavioural queue model carries each sample's own shift forward and is compared with every code on every cycle. Saturation is also provoked while samples keep streaming in, so the clamp and the valid strobe are checked together on the same cycles.

// File: rtl/lms_pkg.sv
package lms_pkg;
  // Strobes sent from the control sequencer to the datapath
  typedef struct packed {
    logic captureEn;   // register products and shift of the current sample
    logic accumEn;     // add the captured, scaled gradient into the weights
  } lmsStrobe_t;
endpackage

// File: rtl/lms_ctrl.sv
module lms_ctrl
  import lms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  output lmsStrobe_t strobe,
  output logic       weightValid
);
  logic stageValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid  <= 1'b0;
      weightValid <= 1'b0;
    end else begin
      stageValid  <= sampleEn;
      weightValid <= stageValid;
    end
  end

  always_comb begin
    strobe.captureEn = sampleEn;
    strobe.accumEn   = stageValid;
  end
endmodule

// File: rtl/lms_sat_acc.sv
module lms_sat_acc #(
  parameter int GRAD_W  = 25,
  parameter int ACC_W   = 28,
  parameter int CODE_W  = 16,
  parameter int SHIFT_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     accumEn,
  input  logic signed [GRAD_W-1:0] grad,
  input  logic [SHIFT_W-1:0]       shiftAmt,
  output logic [CODE_W-1:0]        code
);
  localparam int EXT_W = ACC_W + 1;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  accR;
  logic signed [ACC_W-1:0]  accNext;
  logic signed [GRAD_W-1:0] scaled;
  logic signed [EXT_W-1:0]  sumExt;

  assign scaled = grad >>> shiftAmt;
  assign sumExt = EXT_W'(accR) + EXT_W'(scaled);

  always_comb begin
    if (sumExt[EXT_W-1] != sumExt[EXT_W-2]) begin
      accNext = sumExt[EXT_W-1] ? ACC_MIN : ACC_MAX;
    end else begin
      accNext = sumExt[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR <= '0;
    end else if (accumEn) begin
      accR <= accNext;
    end
  end

  // offset binary: invert the sign bit of the top CODE_W bits
  assign code = {~accR[ACC_W-1], accR[ACC_W-2 -: CODE_W-1]};
endmodule

// File: rtl/lms_tap_slice.sv
module lms_tap_slice
  import lms_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 28,
  parameter int CODE_W   = 16,
  parameter int SHIFT_W  = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  lmsStrobe_t                 strobe,
  input  logic signed [SAMPLE_W-1:0] xI,
  input  logic signed [SAMPLE_W-1:0] xQ,
  input  logic signed [SAMPLE_W-1:0] eI,
  input  logic signed [SAMPLE_W-1:0] eQ,
  input  logic [SHIFT_W-1:0]         shiftIn,
  output logic [CODE_W-1:0]          codeI,
  output logic [CODE_W-1:0]          codeQ
);
  localparam int PROD_W = 2 * SAMPLE_W;
  localparam int GRAD_W = PROD_W + 1;

  logic signed [PROD_W-1:0] prodII, prodQQ, prodIQ, prodQI;
  logic signed [GRAD_W-1:0] gradINext, gradQNext;
  logic signed [GRAD_W-1:0] gradIR, gradQR;
  logic [SHIFT_W-1:0]       shiftR;

  assign prodII = PROD_W'(xI) * PROD_W'(eI);
  assign prodQQ = PROD_W'(xQ) * PROD_W'(eQ);
  assign prodIQ = PROD_W'(xI) * PROD_W'(eQ);
  assign prodQI = PROD_W'(xQ) * PROD_W'(eI);

  // real and imaginary part of conj(x) * e
  assign gradINext = GRAD_W'(prodII) + GRAD_W'(prodQQ);
  assign gradQNext = GRAD_W'(prodIQ) - GRAD_W'(prodQI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gradIR <= '0;
      gradQR <= '0;
      shiftR <= '0;
    end else if (strobe.captureEn) begin
      gradIR <= gradINext;
      gradQR <= gradQNext;
      shiftR <= shiftIn;
    end
  end

  lms_sat_acc #(
    .GRAD_W(GRAD_W), .ACC_W(ACC_W), .CODE_W(CODE_W), .SHIFT_W(SHIFT_W)
  ) uAccI (
    .clk(clk), .rstN(rstN), .accumEn(strobe.accumEn),
    .grad(gradIR), .shiftAmt(shiftR), .code(codeI)
  );

  lms_sat_acc #(
    .GRAD_W(GRAD_W), .ACC_W(ACC_W), .CODE_W(CODE_W), .SHIFT_W(SHIFT_W)
  ) uAccQ (
    .clk(clk), .rstN(rstN), .accumEn(strobe.accumEn),
    .grad(gradQR), .shiftAmt(shiftR), .code(codeQ)
  );
endmodule

// File: rtl/lms_datapath.sv
module lms_datapath
  import lms_pkg::*;
#(
  parameter int NUM_TAPS = 3,
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 28,
  parameter int CODE_W   = 16,
  parameter int SHIFT_W  = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  lmsStrobe_t                   strobe,
  input  logic [SHIFT_W-1:0]           stepShift,
  input  logic [NUM_TAPS*SAMPLE_W-1:0] tapI,
  input  logic [NUM_TAPS*SAMPLE_W-1:0] tapQ,
  input  logic [SAMPLE_W-1:0]          errI,
  input  logic [SAMPLE_W-1:0]          errQ,
  output logic [NUM_TAPS*CODE_W-1:0]   weightICode,
  output logic [NUM_TAPS*CODE_W-1:0]   weightQCode
);
  for (genvar t = 0; t < NUM_TAPS; t++) begin : gTap
    lms_tap_slice #(
      .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .CODE_W(CODE_W), .SHIFT_W(SHIFT_W)
    ) uSlice (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .xI     ($signed(tapI[t*SAMPLE_W +: SAMPLE_W])),
      .xQ     ($signed(tapQ[t*SAMPLE_W +: SAMPLE_W])),
      .eI     ($signed(errI)),
      .eQ     ($signed(errQ)),
      .shiftIn(stepShift),
      .codeI  (weightICode[t*CODE_W +: CODE_W]),
      .codeQ  (weightQCode[t*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/lms_weight_updater.sv
module lms_weight_updater
  import lms_pkg::*;
#(
  parameter int NUM_TAPS = 3,
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 28,
  parameter int CODE_W   = 16,
  parameter int SHIFT_W  = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleEn,
  input  logic [SHIFT_W-1:0]           stepShift,
  input  logic [NUM_TAPS*SAMPLE_W-1:0] tapI,
  input  logic [NUM_TAPS*SAMPLE_W-1:0] tapQ,
  input  logic [SAMPLE_W-1:0]          errI,
  input  logic [SAMPLE_W-1:0]          errQ,
  output logic                         weightValid,
  output logic [NUM_TAPS*CODE_W-1:0]   weightICode,
  output logic [NUM_TAPS*CODE_W-1:0]   weightQCode
);
  lmsStrobe_t strobe;

  lms_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn),
    .strobe(strobe), .weightValid(weightValid)
  );

  lms_datapath #(
    .NUM_TAPS(NUM_TAPS), .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W),
    .CODE_W(CODE_W), .SHIFT_W(SHIFT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepShift(stepShift),
    .tapI(tapI), .tapQ(tapQ), .errI(errI), .errQ(errQ),
    .weightICode(weightICode), .weightQCode(weightQCode)
  );
endmodule

// File: rtl/lms_weight_updater_chk.sv
module lms_weight_updater_chk #(
  parameter int NUM_TAPS = 3,
  parameter int CODE_W   = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       sampleEn,
  input logic                       weightValid,
  input logic [NUM_TAPS*CODE_W-1:0] weightICode,
  input logic [NUM_TAPS*CODE_W-1:0] weightQCode
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1: nothing has reached the accumulators yet
  p_mid_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0) |-> (weightICode == {NUM_TAPS{MID}}) &&
                           (weightQCode == {NUM_TAPS{MID}}) && !weightValid);

  // R8: strobe follows an accepted sample by exactly two edges
  p_valid_after_sample_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) && $past(sampleEn, 2) |-> weightValid);

  p_valid_only_for_sample_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) && !$past(sampleEn, 2) |-> !weightValid);

  // R5: codes move only on a strobe cycle
  p_hold_without_sample_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1) && !weightValid |->
      $stable(weightICode) && $stable(weightQCode));

  for (genvar t = 0; t < NUM_TAPS; t++) begin : gTapChk
    // R6: one update step is far smaller than a quarter range, so a jump
    // between the top and bottom quarters means the accumulator wrapped
    p_no_wrap_i_r6: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 2'd1) && ($past(weightICode[t*CODE_W+CODE_W-1 -: 2]) == 2'b11)
        |-> weightICode[t*CODE_W+CODE_W-1 -: 2] != 2'b00);
    p_no_wrap_lo_i_r6: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 2'd1) && ($past(weightICode[t*CODE_W+CODE_W-1 -: 2]) == 2'b00)
        |-> weightICode[t*CODE_W+CODE_W-1 -: 2] != 2'b11);
    p_no_wrap_q_r6: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 2'd1) && ($past(weightQCode[t*CODE_W+CODE_W-1 -: 2]) == 2'b11)
        |-> weightQCode[t*CODE_W+CODE_W-1 -: 2] != 2'b00);
    p_no_wrap_lo_q_r6: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 2'd1) && ($past(weightQCode[t*CODE_W+CODE_W-1 -: 2]) == 2'b00)
        |-> weightQCode[t*CODE_W+CODE_W-1 -: 2] != 2'b11);
  end
endmodule

bind lms_weight_updater lms_weight_updater_chk #(
  .NUM_TAPS(NUM_TAPS), .CODE_W(CODE_W)
) uChk (
  .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .weightValid(weightValid),
  .weightICode(weightICode), .weightQCode(weightQCode)
);

// File: tb/sim_lms_weight_updater.sv
module sim_lms_weight_updater;
  localparam longint ACC_MAX = (64'sd1 <<< 27) - 1;
  localparam longint ACC_MIN = -(64'sd1 <<< 27);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleEn = 1'b0;
  logic [4:0]  stepShift = '0;
  logic [35:0] tapIBus = '0;
  logic [35:0] tapQBus = '0;
  logic [11:0] errI = '0;
  logic [11:0] errQ = '0;
  logic        weightValid;
  logic [47:0] wI, wQ;

  always #10 clk = ~clk;

  lms_weight_updater u0 (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .stepShift(stepShift),
    .tapI(tapIBus), .tapQ(tapQBus), .errI(errI), .errQ(errQ),
    .weightValid(weightValid), .weightICode(wI), .weightQCode(wQ)
  );

  typedef struct {
    bit     v;
    int     sh;
    longint gI[3];
    longint gQ[3];
  } rec_t;

  rec_t   pipeQ[$];
  longint mAccI[3];
  longint mAccQ[3];
  bit     mValid;
  int     checks = 0;
  int     fails = 0;
  string  phase = "R1";
  bit     done = 1'b0;
  int     xIv[3];
  int     xQv[3];
  int     eIv, eQv;
  int unsigned seed = 32'h1234_5678;

  function automatic longint sx(logic [11:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint clampAcc(longint a);
    if (a > ACC_MAX) return ACC_MAX;
    if (a < ACC_MIN) return ACC_MIN;
    return a;
  endfunction

  function automatic int codeOf(longint a);
    return int'(((a >>> 12) + 32768) & 65535);
  endfunction

  function automatic int rnd12();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 4096) - 2048;
  endfunction

  task automatic check(string req, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural model: every edge enqueues, the entry one edge older is applied
  always @(posedge clk) begin : model
    rec_t r;
    rec_t a;
    if (!rstN) begin
      pipeQ.delete();
      for (int t = 0; t < 3; t++) begin mAccI[t] = 0; mAccQ[t] = 0; end
      mValid = 1'b0;
    end else begin
      r.v  = sampleEn;
      r.sh = int'(stepShift);
      for (int t = 0; t < 3; t++) begin
        r.gI[t] = sx(tapIBus[t*12 +: 12]) * sx(errI) + sx(tapQBus[t*12 +: 12]) * sx(errQ);
        r.gQ[t] = sx(tapIBus[t*12 +: 12]) * sx(errQ) - sx(tapQBus[t*12 +: 12]) * sx(errI);
      end
      pipeQ.push_back(r);
      mValid = 1'b0;
      if (pipeQ.size() > 1) begin
        a = pipeQ.pop_front();
        mValid = a.v;
        if (a.v) begin
          for (int t = 0; t < 3; t++) begin
            mAccI[t] = clampAcc(mAccI[t] + (a.gI[t] >>> a.sh));
            mAccQ[t] = clampAcc(mAccQ[t] + (a.gQ[t] >>> a.sh));
          end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check({phase, " valid"}, weightValid == mValid, weightValid, mValid);
      for (int t = 0; t < 3; t++) begin
        check({phase, " I code"}, int'(wI[t*16 +: 16]) == codeOf(mAccI[t]),
              wI[t*16 +: 16], codeOf(mAccI[t]));
        check({phase, " Q code"}, int'(wQ[t*16 +: 16]) == codeOf(mAccQ[t]),
              wQ[t*16 +: 16], codeOf(mAccQ[t]));
      end
    end
  end

  task automatic drive(bit en, int sh);
    @(negedge clk);
    for (int t = 0; t < 3; t++) begin
      tapIBus[t*12 +: 12] = 12'(xIv[t]);
      tapQBus[t*12 +: 12] = 12'(xQv[t]);
    end
    errI      = 12'(eIv);
    errQ      = 12'(eQv);
    stepShift = 5'(sh);
    sampleEn  = en;
  endtask

  task automatic setAll(int xi, int xq, int ei, int eq);
    for (int t = 0; t < 3; t++) begin xIv[t] = xi; xQv[t] = xq; end
    eIv = ei;
    eQv = eq;
  endtask

  task automatic randomize_inputs();
    for (int t = 0; t < 3; t++) begin xIv[t] = rnd12(); xQv[t] = rnd12(); end
    eIv = rnd12();
    eQv = rnd12();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleEn = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset I", wI == {3{16'h8000}}, wI, {3{16'h8000}});
    check("R1 reset Q", wQ == {3{16'h8000}}, wQ, {3{16'h8000}});
    check("R1 reset valid", weightValid == 1'b0, weightValid, 0);
    rstN = 1'b1;
  endtask

  initial begin
    logic [15:0] held;
    setAll(0, 0, 0, 0);
    doReset();

    // R2 R3 R7 R8 R9: known single update
    phase = "R2";
    xIv[0] = 64;  xQv[0] = 0;
    xIv[1] = 0;   xQv[1] = 64;
    xIv[2] = 0;   xQv[2] = 0;
    eIv = 64; eQv = 0;
    drive(1'b1, 0);
    setAll(0, 0, 0, 0);
    drive(1'b0, 0);
    check("R8 no strobe one edge after", weightValid == 1'b0, weightValid, 0);
    drive(1'b0, 0);
    check("R8 strobe two edges after", weightValid == 1'b1, weightValid, 1);
    drive(1'b0, 0);
    check("R8 strobe one cycle wide", weightValid == 1'b0, weightValid, 0);
    check("R7 R2 tap0 I +4096", wI[15:0] == 16'h8001, wI[15:0], 16'h8001);
    check("R3 tap1 Q conj sign", wQ[31:16] == 16'h7FFF, wQ[31:16], 16'h7FFF);
    check("R9 tap2 untouched", wI[47:32] == 16'h8000, wI[47:32], 16'h8000);

    // R4: arithmetic shift rounds toward minus infinity
    doReset();
    phase = "R4";
    setAll(0, 0, 64, 0);
    xIv[0] = -64;
    drive(1'b1, 13);
    setAll(0, 0, 0, 0);
    repeat (3) drive(1'b0, 0);
    check("R4 -4096>>>13 gives -1", wI[15:0] == 16'h7FFF, wI[15:0], 16'h7FFF);

    // R4 R9: back-to-back samples, shift changes every cycle
    for (int k = 0; k < 120; k++) begin
      randomize_inputs();
      drive(1'b1, (k * 7) % 32);
    end

    // R5: gaps between samples
    phase = "R5";
    for (int k = 0; k < 80; k++) begin
      randomize_inputs();
      drive(k % 3 == 0, 6 + (k % 9));
    end
    repeat (3) drive(1'b0, 0);
    held = wI[31:16];
    for (int k = 0; k < 5; k++) begin
      setAll(-2048, -2048, -2048, -2048);
      drive(1'b0, 0);
    end
    check("R5 no change while idle", wI[31:16] == held, wI[31:16], held);

    // R6: drive to positive rail, then negative rail, streaming
    phase = "R6";
    setAll(-2048, -2048, -2048, -2048);
    xQv[1] = 2047;
    for (int k = 0; k < 40; k++) drive(1'b1, 0);
    setAll(0, 0, 0, 0);
    repeat (3) drive(1'b0, 0);
    check("R6 R7 I at +max", wI[15:0] == 16'hFFFF, wI[15:0], 16'hFFFF);
    check("R6 tap1 Q at +max", wQ[31:16] == 16'hFFFF, wQ[31:16], 16'hFFFF);
    setAll(-2048, -2048, 2047, 2047);
    for (int k = 0; k < 80; k++) drive(1'b1, 0);
    setAll(0, 0, 0, 0);
    repeat (3) drive(1'b0, 0);
    check("R6 R7 I at -max", wI[15:0] == 16'h0000, wI[15:0], 16'h0000);

    // R2 R3: mixed random traffic with moderate step sizes
    phase = "R3";
    for (int k = 0; k < 200; k++) begin
      randomize_inputs();
      drive(k % 5 != 4, 8 + (k % 13));
    end
    repeat (3) drive(1'b0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule